// File: doc/BRIEF.md
# Load/Store Alignment Unit

This block sits between the load/store stage of a processor and a 32-bit byte-addressable memory port. It takes one access request at a time. A request carries a byte address, an access size, a signed-load flag, a write flag, write data and a misalignment policy. The unit turns the request into one or two word-wide memory transactions and drives per-lane byte enables. For loads it returns the result zero-extended or sign-extended to 32 bits.

Misaligned requests are handled by the policy chosen for each request. Under the truncating policy the offending low address bits are cleared. Under the faulting policy the request is refused with a fault pulse and no memory traffic. Under the splitting policy the access is carried out transparently and may take two transactions. Byte order is little-endian: byte lane k of a memory word holds the byte at word address + k.

Top module: `lsu_align`

## Requirements
- R1: Every memory transaction uses a word-aligned address (bits [1:0] zero). An access whose bytes lie within one word uses exactly one transaction. The access size codes are 0 = byte, 1 = halfword, 2 = word. A byte access at byte offset k touches only lane k.
- R2: A byte or halfword load with `req_signed` = 0 returns the loaded value with the upper bits zero.
- R3: A byte or halfword load with `req_signed` = 1 returns the loaded value with the upper bits copied from its top bit.
- R4: Policy code 0 (truncate): a misaligned access clears the address bits that break alignment (bits [1:0] for a word, bit 0 for a halfword) and proceeds on the aligned address.
- R5: Policy codes 1 and 3 (fault): a misaligned access raises `rsp_fault` for one cycle, issues no memory transaction, and leaves memory unchanged. A halfword is misaligned when address bit 0 is set. A word is misaligned when either of address bits [1:0] is set.
- R6: Policy code 2 (split): an access that crosses a word boundary issues the lower word first, then the next word (address + 4, wrapping at the top of the address space). `rsp_done` is raised only after both transactions complete, and the load result equals that of the same bytes read in one access.
- R7: The two byte-enable masks of a split store together cover exactly the bytes being written. Bytes outside the access keep their contents.
- R8: Under policy 2, a misaligned halfword that stays inside one word uses a single transaction.
- R9: `req_ready` is high only while the unit is idle. A request is accepted only then. `rsp_done` is a one-cycle pulse.
- R10: An aligned access gives the same result and the same transaction count under every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend a load |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, right-aligned |
| req_policy | input | 2 | 0 truncate, 1/3 fault, 2 split |
| mem_valid | output | 1 | Memory transaction active |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_we | output | 1 | Transaction is a write |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Read word, valid with ack |
| mem_ack | input | 1 | Transaction completes this cycle |
| rsp_done | output | 1 | Access finished (one cycle) |
| rsp_fault | output | 1 | Alignment fault (one cycle) |
| rsp_rdata | output | 32 | Extended load result |

## Verification
The first requests are aligned words, halfwords and bytes at every lane offset, issued under all three policies. These show that lane selection and extension are right and that the policy has no effect on aligned accesses. Data with the top bit set in some bytes and clear in others separates sign extension from zero extension. The same misaligned addresses are then replayed under each policy, which tells truncation, faulting and splitting apart by result and by counted transactions. Split stores across a word boundary, including the wrap from the top address to zero, are followed by whole-word reads of both neighbours, which expose any stray byte enable.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    POL_TRUNC  = 2'd0,
    POL_FAULT  = 2'd1,
    POL_SPLIT  = 2'd2,
    POL_FAULT2 = 2'd3
  } align_pol_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_lane_plan.sv
module lsu_lane_plan
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        policy,
  input  logic [DATA_W-1:0] wdata,
  output logic              fault,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFS_W-1:0]  ofs,
  output logic [LANES-1:0]  be_lo,
  output logic [LANES-1:0]  be_hi,
  output logic [DATA_W-1:0] wd_lo,
  output logic [DATA_W-1:0] wd_hi,
  output logic              two_beats
);
  logic              misal;
  logic [ADDR_W-1:0] eff;
  logic [LANES-1:0]  base_mask;
  logic [2*LANES-1:0]  lanes;
  logic [2*DATA_W-1:0] wide;

  always_comb begin
    unique case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = addr[0];
      default: misal = |addr[OFS_W-1:0];
    endcase

    eff = addr;
    if (policy == POL_TRUNC && misal) begin
      if (size == SZ_HALF) eff[0] = 1'b0;
      else                 eff[OFS_W-1:0] = '0;
    end

    fault = misal && (policy == POL_FAULT || policy == POL_FAULT2);

    unique case (size)
      SZ_BYTE: base_mask = LANES'(1);
      SZ_HALF: base_mask = LANES'(3);
      default: base_mask = '1;
    endcase

    ofs       = eff[OFS_W-1:0];
    lanes     = {{LANES{1'b0}}, base_mask} << ofs;
    wide      = {{DATA_W{1'b0}}, wdata} << {ofs, 3'b000};
    be_lo     = lanes[LANES-1:0];
    be_hi     = lanes[2*LANES-1:LANES];
    wd_lo     = wide[DATA_W-1:0];
    wd_hi     = wide[2*DATA_W-1:DATA_W];
    two_beats = |be_hi;
    word_addr = {eff[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFS_W = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] result
);
  logic [2*DATA_W-1:0] shifted;

  always_comb begin
    shifted = {hi_word, lo_word} >> {ofs, 3'b000};
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){sgn & shifted[7]}}, shifted[7:0]};
      SZ_HALF: result = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
      default: result = shifted[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_policy,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_rdata
);
  lsu_state_e state;

  logic              p_fault, p_two;
  logic [ADDR_W-1:0] p_waddr;
  logic [OFS_W-1:0]  p_ofs;
  logic [LANES-1:0]  p_be_lo, p_be_hi;
  logic [DATA_W-1:0] p_wd_lo, p_wd_hi;

  logic              two_q, sgn_q;
  logic [1:0]        size_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [LANES-1:0]  be_hi_q;
  logic [DATA_W-1:0] wd_hi_q, lo_q;
  logic [DATA_W-1:0] merge_lo, merged;

  lsu_lane_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
    .addr(req_addr), .size(req_size), .policy(req_policy), .wdata(req_wdata),
    .fault(p_fault), .word_addr(p_waddr), .ofs(p_ofs),
    .be_lo(p_be_lo), .be_hi(p_be_hi), .wd_lo(p_wd_lo), .wd_hi(p_wd_hi),
    .two_beats(p_two)
  );

  assign merge_lo = (state == ST_HI) ? lo_q : mem_rdata;

  lsu_load_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_word(merge_lo), .hi_word(mem_rdata), .ofs(ofs_q),
    .size(size_q), .sgn(sgn_q), .result(merged)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
      two_q     <= 1'b0;
      sgn_q     <= 1'b0;
      size_q    <= '0;
      ofs_q     <= '0;
      be_hi_q   <= '0;
      wd_hi_q   <= '0;
      lo_q      <= '0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (p_fault) begin
              rsp_fault <= 1'b1;
            end else begin
              mem_valid <= 1'b1;
              mem_addr  <= p_waddr;
              mem_we    <= req_write;
              mem_be    <= p_be_lo;
              mem_wdata <= p_wd_lo;
              two_q     <= p_two;
              sgn_q     <= req_signed;
              size_q    <= req_size;
              ofs_q     <= p_ofs;
              be_hi_q   <= p_be_hi;
              wd_hi_q   <= p_wd_hi;
              state     <= ST_LO;
            end
          end
        end
        ST_LO: begin
          if (mem_ack) begin
            lo_q <= mem_rdata;
            if (two_q) begin
              mem_addr  <= mem_addr + ADDR_W'(LANES);
              mem_be    <= be_hi_q;
              mem_wdata <= wd_hi_q;
              state     <= ST_HI;
            end else begin
              mem_valid <= 1'b0;
              rsp_done  <= 1'b1;
              rsp_rdata <= mem_we ? '0 : merged;
              state     <= ST_IDLE;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            mem_valid <= 1'b0;
            rsp_done  <= 1'b1;
            rsp_rdata <= mem_we ? '0 : merged;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic              rsp_done,
  input logic              rsp_fault
);
  // R1: transactions always target a whole word
  a_r1_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  // R5: a fault response carries no memory traffic and no completion
  a_r5_fault_no_txn: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (!mem_valid && !rsp_done));

  // R6: a transaction following a completed one is the next word up
  a_r6_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(mem_valid && mem_ack)) |-> mem_addr == $past(mem_addr) + ADDR_W'(4));

  // R7: a store transaction always writes at least one lane
  a_r7_store_lanes: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we) |-> mem_be != 4'b0000);

  // R9: busy while memory is in use
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  // R9: completion lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
  .rsp_done(rsp_done), .rsp_fault(rsp_fault)
);

// File: tb/sim_lsu_align.sv
`timescale 1ns/1ps
module sim_lsu_align;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_policy = '0;
  logic        mem_valid, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_rdata;

  always #5 clk = ~clk;

  lsu_align #(.ADDR_W(AW)) u0 (.*);

  // memory: 16 words, same-cycle acknowledge
  logic [31:0] dmem [16];
  assign mem_ack   = mem_valid;
  assign mem_rdata = dmem[mem_addr[5:2]];
  always @(posedge clk)
    if (mem_valid && mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) dmem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];

  // reference byte model
  logic [7:0] mbyte [64];

  typedef struct {
    logic        fault;
    logic        wr;
    logic [31:0] val;
    int          beats;
    string       tag;
  } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0, beat_cnt = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_valid) beat_cnt++;
      if (rsp_done || rsp_fault) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected response", 32'(rsp_done), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_fault == e.fault, {e.tag, " fault"}, 32'(rsp_fault), 32'(e.fault));
          chk(beat_cnt == e.beats, {e.tag, " beats"}, beat_cnt, e.beats);
          if (!e.fault && !e.wr)
            chk(rsp_rdata == e.val, {e.tag, " data"}, rsp_rdata, e.val);
        end
        beat_cnt = 0;
      end
    end
  end

  task automatic do_req(input logic [5:0] a, input logic [1:0] sz, input logic sg,
                        input logic wr, input logic [31:0] wd, input logic [1:0] pol,
                        input string tag);
    logic mis, flt;
    logic [5:0] eff;
    int nb;
    exp_t e;
    nb  = 1 << sz;
    mis = (sz == 2'd1) ? a[0] : (sz == 2'd2) ? (a[1:0] != 0) : 1'b0;
    eff = a;
    if (pol == 2'd0 && mis) eff = (sz == 2'd1) ? {a[5:1], 1'b0} : {a[5:2], 2'b00};
    flt = mis && (pol == 2'd1 || pol == 2'd3);
    e.fault = flt; e.wr = wr; e.tag = tag; e.val = '0;
    e.beats = flt ? 0 : ((int'(eff[1:0]) + nb > 4) ? 2 : 1);
    if (!flt) begin
      for (int i = 0; i < nb; i++) begin
        if (wr) mbyte[6'(eff + 6'(i))] = wd[8*i +: 8];
        else    e.val[8*i +: 8] = mbyte[6'(eff + 6'(i))];
      end
      if (!wr && sz == 2'd0) e.val = {{24{sg & e.val[7]}}, e.val[7:0]};
      if (!wr && sz == 2'd1) e.val = {{16{sg & e.val[15]}}, e.val[15:0]};
    end
    q.push_back(e);
    @(negedge clk);
    req_addr = AW'(a); req_size = sz; req_signed = sg; req_write = wr;
    req_wdata = wd; req_policy = pol; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!flt) chk(req_ready == 1'b0, {tag, " R9 busy"}, 32'(req_ready), 0);
    while (!(rsp_done || rsp_fault)) @(negedge clk);
    @(negedge clk);
    chk(!rsp_done && !rsp_fault, {tag, " R9 pulse"}, 32'({rsp_done, rsp_fault}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mbyte[i] = 8'(i * 37 + 5);
    for (int w = 0; w < 16; w++)
      dmem[w] = {mbyte[4*w+3], mbyte[4*w+2], mbyte[4*w+1], mbyte[4*w]};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_valid && !rsp_done && !rsp_fault, "R9 reset state",
        32'({req_ready, mem_valid, rsp_done, rsp_fault}), 32'h8);

    do_req(6'd8,  2'd2, 0, 1, 32'hDEADBEEF, 2'd2, "R1 aligned word store");
    do_req(6'd8,  2'd2, 0, 0, 0, 2'd2, "R1 aligned word load");
    do_req(6'd16, 2'd2, 0, 1, 32'h80F17F2A, 2'd1, "R10 word store fault pol");
    do_req(6'd17, 2'd0, 0, 0, 0, 2'd0, "R1 byte lane1");
    do_req(6'd18, 2'd0, 0, 0, 0, 2'd2, "R2 byte zero ext");
    do_req(6'd18, 2'd0, 1, 0, 0, 2'd2, "R3 byte sign ext");
    do_req(6'd17, 2'd0, 1, 0, 0, 2'd1, "R3 byte positive sign");
    do_req(6'd18, 2'd1, 1, 0, 0, 2'd0, "R3 half sign ext");
    do_req(6'd18, 2'd1, 0, 0, 0, 2'd1, "R2 half zero ext");
    do_req(6'd16, 2'd1, 1, 0, 0, 2'd2, "R10 half pol2");
    do_req(6'd16, 2'd1, 1, 0, 0, 2'd0, "R10 half pol0");
    do_req(6'd19, 2'd2, 0, 0, 0, 2'd0, "R4 truncate word load");
    do_req(6'd21, 2'd1, 0, 1, 32'h0000A55A, 2'd0, "R4 truncate half store");
    do_req(6'd20, 2'd2, 0, 0, 0, 2'd2, "R4 truncate store check");
    do_req(6'd17, 2'd2, 0, 0, 0, 2'd1, "R5 fault word load");
    do_req(6'd23, 2'd1, 0, 1, 32'h00001234, 2'd1, "R5 fault half store");
    do_req(6'd22, 2'd2, 0, 1, 32'h11223344, 2'd3, "R5 fault code3 store");
    do_req(6'd20, 2'd2, 0, 0, 0, 2'd2, "R5 memory unchanged");
    do_req(6'd18, 2'd2, 0, 0, 0, 2'd2, "R6 split word load");
    do_req(6'd19, 2'd1, 1, 0, 0, 2'd2, "R6 split half load");
    do_req(6'd17, 2'd1, 0, 0, 0, 2'd2, "R8 inner half load");
    do_req(6'd29, 2'd1, 0, 1, 32'h0000C3C3, 2'd2, "R8 inner half store");
    do_req(6'd30, 2'd2, 0, 1, 32'hCAFEF00D, 2'd2, "R7 split word store");
    do_req(6'd28, 2'd2, 0, 0, 0, 2'd2, "R7 lower word after split");
    do_req(6'd32, 2'd2, 0, 0, 0, 2'd2, "R7 upper word after split");
    do_req(6'd43, 2'd1, 0, 1, 32'h00007E81, 2'd2, "R7 split half store");
    do_req(6'd40, 2'd2, 0, 0, 0, 2'd1, "R7 word below half split");
    do_req(6'd44, 2'd2, 0, 0, 0, 2'd0, "R7 word above half split");
    do_req(6'd62, 2'd2, 0, 1, 32'h0BADC0DE, 2'd2, "R6 wrap split store");
    do_req(6'd62, 2'd2, 0, 0, 0, 2'd2, "R6 wrap split load");
    do_req(6'd0,  2'd2, 0, 0, 0, 2'd1, "R7 word after wrap");
    do_req(6'd60, 2'd2, 0, 0, 0, 2'd0, "R7 word before wrap");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 responses outstanding", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule